// File: doc/BRIEF.md
# Single-Data-Transfer Execution Unit

This block accepts one 32-bit memory-transfer instruction word on a start pulse and carries it out against its own sixteen-entry, 32-bit register file and a word-addressed data memory. It decodes the word into a base register, a data register and an offset. The offset is either a 12-bit unsigned constant or an index register shifted left. The offset is added to or subtracted from the base. The access address is either the adjusted value (pre-indexed) or the untouched base (post-indexed). The unit then performs a word or single-byte read or write, and where the mode calls for it, it writes the adjusted address back into the base register.

The operation takes several cycles and ends with a one-cycle done pulse. Words that do not belong to this instruction class, or that carry a condition other than "always", finish at once as no-ops. Offsets that ask for a shift the unit does not support are reported through an illegal flag that is raised together with done, and they leave all state untouched. A debug read port exposes any register so that the surrounding system or a bench can observe results.

Top module: `ldst_exec_unit`

## Requirements
- R1: After reset every register reads 0 through the debug port, done is low and neither memory enable is active.
- R2: A word whose bits 31:28 are not 1110, or whose bits 27:26 are not 01, performs no memory access, changes no register, raises done with illegal low, and done comes 2 cycles after the start edge.
- R3: With bit 25 = 1 the offset is the zero-extended 12-bit value in bits 11:0.
- R4: With bit 25 = 0 the offset is the register selected by bits 3:0 shifted left by bits 11:7. If bit 4 = 1 or bits 6:5 are not 00, the word is illegal: illegal is high with done, and no register or memory changes.
- R5: Bit 23 = 1 adds the offset to the base register value (base selected by bits 19:16); bit 23 = 0 subtracts it, modulo 2^32.
- R6: With bit 24 = 1 the access address is base plus or minus the offset; bit 21 = 1 then writes that value into the base register, and bit 21 = 0 leaves it unchanged.
- R7: With bit 24 = 0 the access address is the unmodified base, and the base register always receives base plus or minus the offset.
- R8: With bit 22 = 0 the access is a full word: mem_addr is address bits AW+1:2, address bits 1:0 are ignored, a store (bit 20 = 0) writes the register selected by bits 15:12 with mem_be = 1111, and a load (bit 20 = 1) writes the whole word to that register.
- R9: A byte store (bit 22 = 1, bit 20 = 0) enables only lane n = address bits 1:0 (mem_be bit n, data bits 8n+7:8n) and carries the low byte of the data register in every lane.
- R10: A byte load zero-extends data bits 8n+7:8n, n = address bits 1:0, into the data register.
- R11: When a load names the same register as data and base and base update is active, the register ends with the loaded value.
- R12: Done is a one-cycle pulse; a store or no-op raises it 2 cycles after the start edge and a load 3 cycles after, the memory read data being taken one cycle after the read enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin executing `instr`; taken only when idle |
| instr | input | 32 | Transfer instruction word, sampled with start |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | High with done when the offset form is unsupported |
| mem_addr | output | AW | Word address to data memory |
| mem_rd_en | output | 1 | Memory read request; data returns next cycle |
| mem_wr_en | output | 1 | Memory write request |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd_en |
| dbg_sel | input | 4 | Register index for the debug port |
| dbg_data | output | 32 | Contents of the selected register |

## Verification
The assertions assume that the memory model answers every read exactly one cycle after mem_rd_en and that start is only raised while the unit is idle. They also assume that the bench never changes instr outside the start cycle. The bench drives start for one cycle, waits for done, and only then presents the next word. Its memory returns registered data on every clock. Base, index and data values are loaded beforehand through the unit's own loads from a table, so every address falls within the modelled memory and away from the table.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  localparam int XLEN      = 32;
  localparam int REG_IDX_W = 4;
  localparam int LANES     = XLEN / 8;
  localparam logic [3:0] COND_ALWAYS = 4'b1110;
  localparam logic [1:0] OP_XFER     = 2'b01;

  typedef struct packed {
    logic [3:0]  cond;
    logic [1:0]  op;
    logic        imm_sel;
    logic        pre;
    logic        up;
    logic        bsel;
    logic        wback;
    logic        load;
    logic [3:0]  rn;
    logic [3:0]  rd;
    logic [11:0] ofs;
  } xfer_word_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CAPT,
    ST_FIN
  } xfer_state_t;

  // Shifted index register offset
  function automatic logic [XLEN-1:0] f_reg_offset(logic [XLEN-1:0] rm, logic [4:0] amt);
    return rm << amt;
  endfunction

  // Offset chosen by the immediate-select bit
  function automatic logic [XLEN-1:0] f_offset(xfer_word_t w, logic [XLEN-1:0] rm);
    if (w.imm_sel)
      return {{(XLEN-12){1'b0}}, w.ofs};
    return f_reg_offset(rm, w.ofs[11:7]);
  endfunction

  // Only an immediate-amount left shift is accepted for register offsets
  function automatic logic f_shift_ok(xfer_word_t w);
    return w.imm_sel || (w.ofs[6:4] == 3'b000);
  endfunction

  function automatic logic [XLEN-1:0] f_step(logic [XLEN-1:0] base, logic [XLEN-1:0] ofs,
                                             logic up);
    return up ? base + ofs : base - ofs;
  endfunction

  function automatic logic [LANES-1:0] f_lane_be(logic [1:0] lo, logic is_byte);
    if (is_byte)
      return LANES'(1) << lo;
    return '1;
  endfunction

  function automatic logic [XLEN-1:0] f_store_data(logic [XLEN-1:0] v, logic is_byte);
    if (is_byte)
      return {LANES{v[7:0]}};
    return v;
  endfunction

  function automatic logic [XLEN-1:0] f_load_data(logic [XLEN-1:0] word, logic [1:0] lo,
                                                  logic is_byte);
    logic [XLEN-1:0] sh;
    sh = word >> {lo, 3'b000};
    if (is_byte)
      return {{(XLEN-8){1'b0}}, sh[7:0]};
    return word;
  endfunction

endpackage

// File: rtl/ldst_regfile.sv
module ldst_regfile
  import ldst_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int IW = REG_IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] ra_rn,
  input  logic [IW-1:0] ra_rm,
  input  logic [IW-1:0] ra_rd,
  input  logic [IW-1:0] ra_dbg,
  output logic [W-1:0]  rv_rn,
  output logic [W-1:0]  rv_rm,
  output logic [W-1:0]  rv_rd,
  output logic [W-1:0]  rv_dbg,
  input  logic          we_a,
  input  logic [IW-1:0] wa_a,
  input  logic [W-1:0]  wd_a,
  input  logic          we_b,
  input  logic [IW-1:0] wa_b,
  input  logic [W-1:0]  wd_b
);

  localparam int NREG = 1 << IW;

  logic [W-1:0] regs [NREG];

  // Port A (load data) wins over port B (base update) on the same entry
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (we_a && (wa_a == IW'(g)))
        q <= wd_a;
      else if (we_b && (wa_b == IW'(g)))
        q <= wd_b;
    end
    assign regs[g] = q;
  end

  assign rv_rn  = regs[ra_rn];
  assign rv_rm  = regs[ra_rm];
  assign rv_rd  = regs[ra_rd];
  assign rv_dbg = regs[ra_dbg];

endmodule

// File: rtl/ldst_agen.sv
module ldst_agen
  import ldst_pkg::*;
#(
  parameter int AW = 8
) (
  input  xfer_word_t     iw,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] index_val,
  output logic [AW+1:0]   acc_addr,
  output logic [XLEN-1:0] upd_addr,
  output logic            shift_ok,
  output logic            do_wb
);

  logic [XLEN-1:0] ofs_val;

  always_comb begin
    ofs_val  = f_offset(iw, index_val);
    upd_addr = f_step(base_val, ofs_val, iw.up);
    acc_addr = iw.pre ? (AW+2)'(upd_addr) : (AW+2)'(base_val);
    shift_ok = f_shift_ok(iw);
    do_wb    = !iw.pre || iw.wback;
  end

endmodule

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic exec_ok,
  input  logic is_load,
  output logic accept,
  output logic in_addr,
  output logic in_capt,
  output logic in_fin
);

  xfer_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (start) st_nx = ST_ADDR;
      ST_ADDR: st_nx = (exec_ok && is_load) ? ST_CAPT : ST_FIN;
      ST_CAPT: st_nx = ST_FIN;
      ST_FIN:  st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st <= ST_IDLE;
    else
      st <= st_nx;
  end

  assign accept  = (st == ST_IDLE) && start;
  assign in_addr = (st == ST_ADDR);
  assign in_capt = (st == ST_CAPT);
  assign in_fin  = (st == ST_FIN);

endmodule

// File: rtl/ldst_exec_unit.sv
module ldst_exec_unit
  import ldst_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [XLEN-1:0]      instr,
  output logic                 done,
  output logic                 illegal,
  output logic [AW-1:0]        mem_addr,
  output logic                 mem_rd_en,
  output logic                 mem_wr_en,
  output logic [LANES-1:0]     mem_be,
  output logic [XLEN-1:0]      mem_wdata,
  input  logic [XLEN-1:0]      mem_rdata,
  input  logic [REG_IDX_W-1:0] dbg_sel,
  output logic [XLEN-1:0]      dbg_data
);

  xfer_word_t      ir;
  logic [1:0]      lane_q;
  logic            accept, in_addr, in_capt, in_fin;
  logic [XLEN-1:0] base_val, index_val, data_val;
  logic [AW+1:0]   acc_addr;
  logic [XLEN-1:0] upd_addr;
  logic            shift_ok, do_wb;
  logic            is_xfer, exec_ok, ir_illegal;
  logic            rf_ld_we, rf_wb_we;
  logic [XLEN-1:0] ld_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ir <= '0;
    else if (accept)
      ir <= xfer_word_t'(instr);
  end

  // Lane bits kept from the address cycle: the base may be rewritten there
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lane_q <= '0;
    else if (in_addr)
      lane_q <= acc_addr[1:0];
  end

  ldst_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .exec_ok (exec_ok),
    .is_load (ir.load),
    .accept  (accept),
    .in_addr (in_addr),
    .in_capt (in_capt),
    .in_fin  (in_fin)
  );

  ldst_agen #(.AW(AW)) u_agen (
    .iw        (ir),
    .base_val  (base_val),
    .index_val (index_val),
    .acc_addr  (acc_addr),
    .upd_addr  (upd_addr),
    .shift_ok  (shift_ok),
    .do_wb     (do_wb)
  );

  assign is_xfer    = (ir.cond == COND_ALWAYS) && (ir.op == OP_XFER);
  assign exec_ok    = is_xfer && shift_ok;
  assign ir_illegal = is_xfer && !shift_ok;

  assign rf_wb_we = in_addr && exec_ok && do_wb;
  assign rf_ld_we = in_capt;
  assign ld_val   = f_load_data(mem_rdata, lane_q, ir.bsel);

  ldst_regfile #(.W(XLEN), .IW(REG_IDX_W)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .ra_rn  (ir.rn),
    .ra_rm  (ir.ofs[3:0]),
    .ra_rd  (ir.rd),
    .ra_dbg (dbg_sel),
    .rv_rn  (base_val),
    .rv_rm  (index_val),
    .rv_rd  (data_val),
    .rv_dbg (dbg_data),
    .we_a   (rf_ld_we),
    .wa_a   (ir.rd),
    .wd_a   (ld_val),
    .we_b   (rf_wb_we),
    .wa_b   (ir.rn),
    .wd_b   (upd_addr)
  );

  assign mem_addr  = acc_addr[AW+1:2];
  assign mem_rd_en = in_addr && exec_ok && ir.load;
  assign mem_wr_en = in_addr && exec_ok && !ir.load;
  assign mem_be    = f_lane_be(acc_addr[1:0], ir.bsel);
  assign mem_wdata = f_store_data(data_val, ir.bsel);

  assign done    = in_fin;
  assign illegal = in_fin && ir_illegal;

endmodule

// File: rtl/ldst_exec_chk.sv
module ldst_exec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       illegal,
  input logic       mem_rd_en,
  input logic       mem_wr_en,
  input logic [3:0] mem_be,
  input logic       rf_ld_we,
  input logic       rf_wb_we
);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> rf_ld_we);

  // R12
  capture_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_ld_we |=> done);

  // R12
  store_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> done);

  // R8
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  // R9
  lane_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($countones(mem_be) == 1 || mem_be == 4'hF));

  // R4
  illegal_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  // R2
  finish_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_rd_en && !mem_wr_en && !rf_wb_we && !rf_ld_we));

  // R11
  write_ports_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_ld_we && rf_wb_we));

endmodule

bind ldst_exec_unit ldst_exec_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .illegal   (illegal),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en),
  .mem_be    (mem_be),
  .rf_ld_we  (rf_ld_we),
  .rf_wb_we  (rf_wb_we)
);

// File: tb/sim_ldst_exec_unit.sv
module sim_ldst_exec_unit;

  localparam int AW    = 8;
  localparam int WORDS = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] instr;
  logic        done, illegal;
  logic [AW-1:0] mem_addr;
  logic        mem_rd_en, mem_wr_en;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0]  dbg_sel;
  logic [31:0] dbg_data;

  logic [31:0] mem  [WORDS];
  logic [31:0] emem [WORDS];
  logic [31:0] erf  [16];

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ldst_exec_unit #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .done(done), .illegal(illegal), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );

  // Memory with one-cycle read latency
  always @(posedge clk) begin
    if (mem_wr_en)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [3:0] cd, input logic [1:0] op,
                                      input logic [5:0] f, input logic [3:0] rn,
                                      input logic [3:0] rd, input logic [11:0] o);
    return {cd, op, f, rn, rd, o};
  endfunction

  // Bench-side execution model and comparison
  task automatic run(input logic [31:0] w);
    logic cls, bad, wb;
    logic [31:0] base, ofs, nxt, acc, word, ld, dv;
    logic [AW-1:0] idx;
    int lat, n;
    string tag, mtag;
    cls = (w[31:28] == 4'hE) && (w[27:26] == 2'b01);
    bad = cls && !w[25] && (w[4] || (w[6:5] != 2'b00));
    lat = 2;
    wb  = !w[24] || w[21];
    if (!cls) tag = "R2";
    else if (bad) tag = "R4";
    else if (w[20] && wb && (w[19:16] == w[15:12])) tag = "R11";
    else if (w[20] && w[22]) tag = "R10";
    else if (!w[24]) tag = "R7";
    else if (!w[23]) tag = "R5";
    else if (w[25]) tag = "R3";
    else tag = "R6";
    mtag = tag;
    if (cls && !bad) begin
      base = erf[w[19:16]];
      ofs  = w[25] ? {20'd0, w[11:0]} : (erf[w[3:0]] << w[11:7]);
      nxt  = w[23] ? base + ofs : base - ofs;
      acc  = w[24] ? nxt : base;
      idx  = acc[AW+1:2];
      word = emem[idx];
      dv   = erf[w[15:12]];
      ld   = 32'd0;
      if (w[20]) begin
        lat = 3;
        ld  = w[22] ? ((word >> (8 * acc[1:0])) & 32'hFF) : word;
      end else if (w[22]) begin
        emem[idx][8*acc[1:0] +: 8] = dv[7:0];
        mtag = "R9";
      end else begin
        emem[idx] = dv;
        mtag = "R8";
      end
      if (wb) erf[w[19:16]] = nxt;
      if (w[20]) erf[w[15:12]] = ld;
    end
    @(negedge clk);
    instr = w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk("R12", "done latency", 32'(n), 32'(lat));
    chk("R4", "illegal flag", {31'd0, illegal}, {31'd0, bad});
    @(negedge clk);
    chk("R12", "done width", {31'd0, done}, 32'd0);
    for (int k = 0; k < 16; k++) begin
      dbg_sel = 4'(k);
      #1;
      chk(tag, $sformatf("reg %0d after %h", k, w), dbg_data, erf[k]);
    end
    for (int m = 0; m < WORDS; m++)
      if (mem[m] !== emem[m]) chk(mtag, $sformatf("mem %0d after %h", m, w), mem[m], emem[m]);
    checks++;
  endtask

  // Word load with base R0 (always zero) to set up a register from the table
  task automatic setreg(input logic [3:0] r, input int slot);
    run(enc(4'hE, 2'b01, 6'b111001, 4'd0, r, 12'(4 * slot)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R12 watchdog: actual %h expected %h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int m = 0; m < WORDS; m++) mem[m] = 32'h9E37_79B1 * (m + 1);
    for (int k = 0; k < 4; k++) begin
      mem[k]     = 32'h200 + 32'h11 * k;
      mem[4 + k] = 32'hA1B2_C3D4 ^ (32'h0101_0101 * k);
    end
    mem[8] = 32'd3; mem[9] = 32'd7; mem[10] = 32'd12; mem[11] = 32'd20;
    for (int m = 0; m < WORDS; m++) emem[m] = mem[m];
    for (int k = 0; k < 16; k++) erf[k] = 32'd0;
    rst_n = 1'b0; start = 1'b0; instr = 32'd0; dbg_sel = 4'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "done", {31'd0, done}, 32'd0);
    chk("R1", "rd_en", {31'd0, mem_rd_en}, 32'd0);
    chk("R1", "wr_en", {31'd0, mem_wr_en}, 32'd0);
    for (int k = 0; k < 16; k++) begin
      dbg_sel = 4'(k);
      #1;
      chk("R1", "reset reg", dbg_data, 32'd0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Sweep of every {I,P,U,B,W,L} combination
    for (int c = 0; c < 64; c++) begin
      logic [3:0] rn, rd;
      logic [11:0] o;
      rn = 4'(2 + c % 3);
      rd = (c % 7 == 0) ? rn : 4'(6 + c % 4);
      setreg(rn, c % 4);
      if (rd != rn) setreg(rd, 4 + c % 4);
      setreg(4'd11, 8 + (c + 1) % 4);
      o = c[5] ? 12'(12'h0F0 + c) : {5'(c % 4), 2'b00, 1'b0, 4'd11};
      run(enc(4'hE, 2'b01, 6'(c), rn, rd, o));
    end

    setreg(4'd2, 0);
    setreg(4'd3, 1);
    setreg(4'd6, 5);
    setreg(4'd11, 9);
    // R2 no-op words
    run(enc(4'h0, 2'b01, 6'b111000, 4'd2, 4'd6, 12'h010));
    run(enc(4'hF, 2'b01, 6'b111001, 4'd2, 4'd6, 12'h010));
    run(enc(4'hE, 2'b00, 6'b111001, 4'd2, 4'd6, 12'h010));
    run(enc(4'hE, 2'b10, 6'b111010, 4'd2, 4'd6, 12'h010));
    // R4 unsupported shift forms
    run(enc(4'hE, 2'b01, 6'b011011, 4'd2, 4'd6, {5'd1, 2'b00, 1'b1, 4'd11}));
    run(enc(4'hE, 2'b01, 6'b011000, 4'd2, 4'd6, {5'd1, 2'b01, 1'b0, 4'd11}));
    run(enc(4'hE, 2'b01, 6'b001001, 4'd2, 4'd6, {5'd2, 2'b10, 1'b0, 4'd11}));
    run(enc(4'hE, 2'b01, 6'b011010, 4'd2, 4'd6, {5'd0, 2'b11, 1'b0, 4'd11}));
    // R11 same register as data and base
    run(enc(4'hE, 2'b01, 6'b101001, 4'd3, 4'd3, 12'h004));
    setreg(4'd3, 2);
    run(enc(4'hE, 2'b01, 6'b110111, 4'd3, 4'd3, 12'h009));
    // R3 largest immediate, R5 subtract with byte lanes
    setreg(4'd2, 3);
    run(enc(4'hE, 2'b01, 6'b110001, 4'd2, 4'd7, 12'hFFF));
    run(enc(4'hE, 2'b01, 6'b110100, 4'd2, 4'd6, 12'h0FF));
    run(enc(4'hE, 2'b01, 6'b100101, 4'd2, 4'd8, 12'h003));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule